// File: doc/BRIEF.md
# RTC Interrupt Flag and Alarm Unit

This unit produces the interrupt side of a real-time clock. It watches three event sources: the end of a time update, a match between the running time and the programmed alarm, and a periodic tick from the divider. It holds each event in a sticky flag until the host reads the status byte. It also folds the enabled flags into one summary bit and drives an active-low interrupt pin from that bit.

The alarm is checked at the end of every update. The current seconds, minutes and hours are compared with the three alarm bytes. An alarm byte whose two most significant bits are both one counts as "any value" for its field. The host reads the status byte through a read strobe. That read returns the current contents and empties the flags on the following cycle. Writes aimed at the status byte are accepted on the bus but change nothing.

Top module: `rtc_irq_unit`

## Requirements
- R1: After synchronous reset, `stat_c` is 0x00 and `irq_n` is 1.
- R2: A one-cycle `upd_done` pulse sets the update-ended flag in `stat_c` bit 4, which is visible from the cycle after the pulse.
- R3: When `upd_done` is high and all three time bytes equal their alarm bytes, the alarm flag in `stat_c` bit 5 is set. If any field differs, that update leaves bit 5 clear.
- R4: An alarm byte in the range 0xC0 to 0xFF (top two bits both 1) matches any value of its time field.
- R5: A one-cycle `per_tick` pulse sets the periodic flag in `stat_c` bit 6.
- R6: Flags in bits 6:4 latch whether or not their enables are set, stay set until a read clears them, and bits 3:0 of `stat_c` always read 0.
- R7: `stat_c` bit 7 is 1 exactly when some flag has its enable set. The enables are `irq_en` bit 0 for update-ended, bit 1 for alarm and bit 2 for periodic, corresponding to register B bits 4, 5 and 6.
- R8: `irq_n` is 0 exactly while `stat_c` bit 7 is 1.
- R9: During the cycle `stat_rd` is high, `stat_c` shows the current value. From the next cycle, bits 7:4 are 0.
- R10: An event whose strobe is high in the same cycle as `stat_rd` is not lost. Its flag is set after the read.
- R11: A `stat_wr` pulse has no effect on `stat_c` or `irq_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_done | input | 1 | One-cycle strobe at the end of a time update |
| per_tick | input | 1 | One-cycle periodic interrupt tick |
| time_sec | input | 8 | Current seconds byte |
| time_min | input | 8 | Current minutes byte |
| time_hour | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hour | input | 8 | Alarm hours byte |
| irq_en | input | 3 | Enables: bit0 update-ended, bit1 alarm, bit2 periodic |
| stat_rd | input | 1 | Host read strobe of the status byte |
| stat_wr | input | 1 | Host write strobe to the status byte (ignored) |
| stat_c | output | 8 | Status byte: IRQ summary, three flags, zero nibble |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The alarm comparison is exercised three ways: with all three fields equal, with one field off by one, and with a wildcard byte placed against a differing field. This separates exact matching, rejection of a partial match, and "any value" handling. The summary bit is driven with each flag against a matching enable and against a non-matching enable, which shows that latching and gating are independent. A read is issued both alone and together with a fresh periodic tick, to separate plain clearing from clear-versus-set priority. Write pulses are applied both with flags empty and with a flag set.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NUM_FLAGS = 3;
  localparam int FLG_UF    = 0;
  localparam int FLG_AF    = 1;
  localparam int FLG_PF    = 2;
  localparam int FLAG_LSB  = 4;

  // A byte with its two top bits set stands for "any value".
  function automatic logic is_any(input logic [7:0] b);
    return b[7] & b[6];
  endfunction
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int DW      = 8,
  parameter int NFIELDS = 3
) (
  input  logic [NFIELDS-1:0][DW-1:0] cur,
  input  logic [NFIELDS-1:0][DW-1:0] alm,
  output logic                       hit
);
  import rtc_irq_pkg::*;

  logic [NFIELDS-1:0] field_ok;

  for (genvar f = 0; f < NFIELDS; f++) begin : g_field
    always_comb begin
      field_ok[f] = (alm[f] == cur[f]) || is_any(alm[f][DW-1 -: 8]);
    end
  end

  assign hit = &field_ok;
endmodule

// File: rtl/rtc_flag_latch.sv
module rtc_flag_latch #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_ev,
  input  logic          clr,
  output logic [NF-1:0] flags
);
  logic [NF-1:0] flags_q;

  for (genvar k = 0; k < NF; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)            flags_q[k] <= 1'b0;
      else if (set_ev[k]) flags_q[k] <= 1'b1;   // new event wins over clear
      else if (clr)       flags_q[k] <= 1'b0;
    end
  end

  assign flags = flags_q;

  p_event_sets_r10: assert property (@(posedge clk) disable iff (rst)
    set_ev[0] |=> flags[0]);
  p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && set_ev == '0) |=> flags == '0);
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((flags & $past(flags)) == $past(flags)));
  p_tick_sets_r5: assert property (@(posedge clk) disable iff (rst)
    set_ev[NF-1] |=> flags[NF-1]);
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_done,
  input  logic          per_tick,
  input  logic [DW-1:0] time_sec,
  input  logic [DW-1:0] time_min,
  input  logic [DW-1:0] time_hour,
  input  logic [DW-1:0] alm_sec,
  input  logic [DW-1:0] alm_min,
  input  logic [DW-1:0] alm_hour,
  input  logic [2:0]    irq_en,
  input  logic          stat_rd,
  input  logic          stat_wr,
  output logic [7:0]    stat_c,
  output logic          irq_n
);
  import rtc_irq_pkg::*;

  localparam int NF = NUM_FLAGS;

  logic          alarm_hit;
  logic [NF-1:0] set_ev;
  logic [NF-1:0] flags;
  logic          irqf;

  rtc_alarm_match #(.DW(DW), .NFIELDS(3)) u_match (
    .cur ({time_hour, time_min, time_sec}),
    .alm ({alm_hour, alm_min, alm_sec}),
    .hit (alarm_hit)
  );

  always_comb begin
    set_ev         = '0;
    set_ev[FLG_UF] = upd_done;
    set_ev[FLG_AF] = upd_done & alarm_hit;
    set_ev[FLG_PF] = per_tick;
  end

  rtc_flag_latch #(.NF(NF)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_ev (set_ev),
    .clr    (stat_rd),
    .flags  (flags)
  );

  assign irqf   = |(flags & irq_en);
  assign stat_c = {irqf, flags, 4'b0000};
  assign irq_n  = ~irqf;

  p_alarm_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_done && alarm_hit) |=> stat_c[5]);
  p_update_sets_r2: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> stat_c[4]);
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_en == 3'b000) |-> irq_n);
  p_write_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !stat_rd && !upd_done && !per_tick) |=> $stable(stat_c[6:4]));
endmodule

// File: tb/rtc_irq_unit_test.sv
module rtc_irq_unit_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       upd_done, per_tick, stat_rd, stat_wr;
  logic [7:0] time_sec, time_min, time_hour, alm_sec, alm_min, alm_hour;
  logic [2:0] irq_en;
  logic [7:0] stat_c;
  logic       irq_n;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rtc_irq_unit uut (
    .clk(clk), .rst(rst), .upd_done(upd_done), .per_tick(per_tick),
    .time_sec(time_sec), .time_min(time_min), .time_hour(time_hour),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
    .irq_en(irq_en), .stat_rd(stat_rd), .stat_wr(stat_wr),
    .stat_c(stat_c), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] exp_c, input logic exp_n);
    checks++;
    if (stat_c !== exp_c || irq_n !== exp_n) begin
      errors++;
      $display("FAIL %s: stat_c=%02h irq_n=%0b expected stat_c=%02h irq_n=%0b",
               req, stat_c, irq_n, exp_c, exp_n);
    end
  endtask

  // Drive strobes for one cycle; on return the registered result is visible.
  task automatic pulse(input logic u, input logic t, input logic r, input logic w);
    upd_done = u; per_tick = t; stat_rd = r; stat_wr = w;
    @(negedge clk);
    upd_done = 0; per_tick = 0; stat_rd = 0; stat_wr = 0;
  endtask

  task automatic set_time(input logic [7:0] h, m, s, ah, am, as);
    time_hour = h; time_min = m; time_sec = s;
    alm_hour = ah; alm_min = am; alm_sec = as;
  endtask

  task automatic t_reset;
    rst = 1; upd_done = 0; per_tick = 0; stat_rd = 0; stat_wr = 0; irq_en = 0;
    set_time(8'h01, 8'h02, 8'h03, 8'h11, 8'h12, 8'h13);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset", 8'h00, 1'b1);
  endtask

  task automatic t_update_and_read;
    pulse(1, 0, 0, 0);
    check("R2 update flag", 8'h10, 1'b1);
    stat_rd = 1; #1;
    check("R9 read returns current", 8'h10, 1'b1);
    @(negedge clk); stat_rd = 0;
    check("R9 cleared after read", 8'h00, 1'b1);
  endtask

  task automatic t_alarm;
    set_time(8'h12, 8'h34, 8'h56, 8'h12, 8'h34, 8'h56);
    pulse(1, 0, 0, 0);
    check("R3 alarm exact match", 8'h30, 1'b1);
    irq_en = 3'b010; #1;
    check("R7 alarm enabled", 8'hB0, 1'b0);
    pulse(0, 0, 1, 0);
    check("R8 pin released after read", 8'h00, 1'b1);
    set_time(8'h12, 8'h35, 8'h56, 8'h12, 8'h34, 8'h56);
    pulse(1, 0, 0, 0);
    check("R3 minute mismatch no alarm", 8'h10, 1'b1);
    pulse(0, 0, 1, 0);
    set_time(8'h12, 8'h34, 8'h07, 8'h12, 8'h34, 8'hC5);
    pulse(1, 0, 0, 0);
    check("R4 wildcard seconds", 8'hB0, 1'b0);
    pulse(0, 0, 1, 0);
    set_time(8'h09, 8'h34, 8'h07, 8'hFF, 8'hFF, 8'h80);
    pulse(1, 0, 0, 0);
    check("R4 0x80 is not wildcard", 8'h10, 1'b1);
    pulse(0, 0, 1, 0);
    irq_en = 0;
  endtask

  task automatic t_periodic;
    pulse(0, 1, 0, 0);
    check("R5 periodic latched while masked", 8'h40, 1'b1);
    irq_en = 3'b100; #1;
    check("R7 periodic enabled", 8'hC0, 1'b0);
    irq_en = 3'b011; #1;
    check("R6 mismatched enables", 8'h40, 1'b1);
  endtask

  task automatic t_write_ignore;
    pulse(0, 0, 0, 1);
    check("R11 write with flag set", 8'h40, 1'b1);
    pulse(0, 0, 1, 0);
    pulse(0, 0, 0, 1);
    check("R11 write with flags empty", 8'h00, 1'b1);
  endtask

  task automatic t_read_coincide;
    irq_en = 3'b101;
    pulse(1, 0, 0, 0);
    check("R7 update enabled", 8'h90, 1'b0);
    pulse(0, 1, 1, 0);
    check("R10 tick during read kept", 8'hC0, 1'b0);
    pulse(0, 0, 1, 0);
    check("R9 final clear", 8'h00, 1'b1);
  endtask

  initial begin
    t_reset;
    t_update_and_read;
    t_alarm;
    t_periodic;
    t_write_ignore;
    t_read_coincide;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule